// File: doc/BRIEF.md
# Bounded Character Search Engine

The engine looks for one search character in a string held in memory. The string runs from a start address up to, but not including, an end address. A parameter fixes the unit size at elaboration: either single bytes or 16-bit halfwords. When a start pulse arrives, the engine checks a 32-bit control word. It takes the search character from the low bits of that word, and the reserved bits above the character must be zero. The engine masks both addresses to the selected addressing mode. It then reads units one after another through a plain request/response memory port, keeping only one read outstanding at a time.

At the end it returns a one-cycle done pulse with a 2-bit condition code and the two address values to write back. Code 1 means the character was found. Code 2 means the end of the string was reached. Code 3 means the fixed work budget ran out and the search can be resumed. A nonzero reserved field raises the specification-error flag and no memory is read.

Top module: `strsrch_top`

## Requirements
- R1: In byte mode (HALF_MODE=0) the search character is ctl_word[7:0]. If any bit of ctl_word[31:8] is set, the result is spec_err=1, cc=0, new_start=start_addr and new_end=end_addr, and no memory read is issued.
- R2: In halfword mode (HALF_MODE=1) the search character is ctl_word[15:0]. If any bit of ctl_word[31:16] is set, the block reports a specification error with the same result as R1.
- R3: When the current scan address equals the effective end address, the block finishes with cc=2 and returns new_start=start_addr and new_end=end_addr unchanged.
- R4: When a fetched unit equals the search character, the block finishes with cc=1. new_end is the masked address of that unit and new_start=start_addr.
- R5: If the scan has covered 8192 bytes without a result, the block finishes with cc=3, new_start is the masked next unscanned address and new_end=end_addr. At that point the budget test takes priority over the end-address test.
- R6: In halfword mode, if bit 0 of the masked start and bit 0 of the masked end differ, the effective end address is the masked end plus 1.
- R7: Reads go in ascending address order. Each step advances the address by 1 in byte mode and by 2 in halfword mode. The memory returns a whole unit on mem_rdata.
- R8: The amode encoding is 2'b00 for 24-bit addresses (bits above 23 cleared), 2'b01 for 31-bit addresses (bits above 30 cleared), and 2'b10 or 2'b11 for the full address width. The masking applies to the scan, to every mem_addr and to every address the block computes.
- R9: start is honoured only while the block is idle. mem_req is a one-cycle pulse, and a new request waits for mem_rvalid of the previous one. done is a one-cycle pulse, and cc, spec_err, new_start and new_end hold their values until the next done.
- R10: After reset, done, mem_req, spec_err and cc are 0, and new_start and new_end are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a search (idle only) |
| ctl_word | input | 32 | Search character and reserved field |
| start_addr | input | ADDR_W | First address of the string |
| end_addr | input | ADDR_W | Address just past the string |
| amode | input | 2 | Addressing mode: 00 24-bit, 01 31-bit, 1x full |
| mem_req | output | 1 | One-cycle read request |
| mem_addr | output | ADDR_W | Read address |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 8 or 16 | Read unit (8 bits for byte mode, 16 bits for halfword mode) |
| done | output | 1 | Result valid pulse |
| cc | output | 2 | Condition code |
| spec_err | output | 1 | Reserved control bits were set |
| new_start | output | ADDR_W | Start address to write back |
| new_end | output | ADDR_W | End address to write back |

## Verification
The bench targets the exact budget boundary. An end address 8191 bytes away has to give code 2, and one 8192 bytes away has to give code 3. A design that tests the end before the budget, or that stops one unit early or late, reports the wrong code or the wrong resume address. In halfword mode an end address of the opposite parity has to stop the scan. Without the correction the scan steps past the end and runs on until the budget gives out. Upper address bits are set in the 24-bit and 31-bit modes, so a missing mask shows up on mem_addr and in the returned addresses. A second start pulse is issued mid-scan, and a design that accepts it returns the second search's result.

// File: rtl/strsrch_pkg.sv
package strsrch_pkg;

  typedef enum logic [1:0] {
    CC_NONE    = 2'd0,
    CC_FOUND   = 2'd1,
    CC_END     = 2'd2,
    CC_PARTIAL = 2'd3
  } scan_cc_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_EVAL = 2'd1,
    ST_WAIT = 2'd2
  } scan_state_e;

  localparam logic [1:0] AMODE_24 = 2'b00;
  localparam logic [1:0] AMODE_31 = 2'b01;

endpackage

// File: rtl/strsrch_addr_mask.sv
module strsrch_addr_mask #(
  parameter int ADDR_W = 64
) (
  input  logic [ADDR_W-1:0] addr_in,
  input  logic [1:0]        mode,
  output logic [ADDR_W-1:0] addr_out
);
  import strsrch_pkg::*;

  localparam logic [ADDR_W-1:0] KEEP24 = ADDR_W'(32'h00FF_FFFF);
  localparam logic [ADDR_W-1:0] KEEP31 = ADDR_W'(32'h7FFF_FFFF);

  always_comb begin
    case (mode)
      AMODE_24: addr_out = addr_in & KEEP24;
      AMODE_31: addr_out = addr_in & KEEP31;
      default:  addr_out = addr_in;
    endcase
  end
endmodule

// File: rtl/strsrch_ctl_check.sv
module strsrch_ctl_check #(
  parameter int HALF_MODE = 0,
  parameter int UNIT_W    = 8
) (
  input  logic [31:0]       ctl_word,
  output logic [UNIT_W-1:0] search_char,
  output logic              reserved_set
);
  generate
    if (HALF_MODE != 0) begin : g_half
      assign search_char  = ctl_word[15:0];
      assign reserved_set = |ctl_word[31:16];
    end else begin : g_byte
      assign search_char  = ctl_word[7:0];
      assign reserved_set = |ctl_word[31:8];
    end
  endgenerate
endmodule

// File: rtl/strsrch_seq.sv
module strsrch_seq #(
  parameter int ADDR_W     = 64,
  parameter int UNIT_W     = 8,
  parameter int STEP       = 1,
  parameter int SCAN_BYTES = 8192
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [UNIT_W-1:0] char_in,
  input  logic              bad_in,
  input  logic [ADDR_W-1:0] raw_start,
  input  logic [ADDR_W-1:0] raw_end,
  input  logic [ADDR_W-1:0] base_in,
  input  logic [ADDR_W-1:0] limit_in,
  input  logic [1:0]        amode,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_rvalid,
  input  logic [UNIT_W-1:0] mem_rdata,
  output logic              done,
  output logic [1:0]        cc,
  output logic              spec_err,
  output logic [ADDR_W-1:0] new_start,
  output logic [ADDR_W-1:0] new_end
);
  import strsrch_pkg::*;

  localparam int              LEN_W     = $clog2(SCAN_BYTES) + 1;
  localparam logic [LEN_W-1:0] LEN_LIMIT = LEN_W'(SCAN_BYTES);
  localparam logic [LEN_W-1:0] LEN_STEP  = LEN_W'(STEP);

  scan_state_e       state_q, state_d;
  logic [LEN_W-1:0]  len_q, len_d;
  logic              cap_en;
  logic [UNIT_W-1:0] char_q;
  logic [1:0]        amode_q;
  logic [ADDR_W-1:0] raw_start_q, raw_end_q, base_q, limit_q;

  logic              req_q, req_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic              done_q, done_d;
  scan_cc_e          cc_q, cc_d;
  logic              spec_q, spec_d;
  logic [ADDR_W-1:0] ns_q, ns_d, ne_q, ne_d;

  logic [ADDR_W-1:0] cur_addr, cur_masked;

  assign cur_addr = base_q + ADDR_W'(len_q);

  strsrch_addr_mask #(.ADDR_W(ADDR_W)) u_cur_mask (
    .addr_in (cur_addr),
    .mode    (amode_q),
    .addr_out(cur_masked)
  );

  always_comb begin
    state_d = state_q;
    len_d   = len_q;
    cap_en  = 1'b0;
    req_d   = 1'b0;
    addr_d  = addr_q;
    done_d  = 1'b0;
    cc_d    = cc_q;
    spec_d  = spec_q;
    ns_d    = ns_q;
    ne_d    = ne_q;
    case (state_q)
      ST_IDLE: begin
        if (start) begin
          cap_en = 1'b1;
          if (bad_in) begin
            done_d = 1'b1;
            cc_d   = CC_NONE;
            spec_d = 1'b1;
            ns_d   = raw_start;
            ne_d   = raw_end;
          end else begin
            len_d   = '0;
            state_d = ST_EVAL;
          end
        end
      end
      ST_EVAL: begin
        if (len_q == LEN_LIMIT) begin
          done_d  = 1'b1;
          cc_d    = CC_PARTIAL;
          spec_d  = 1'b0;
          ns_d    = cur_masked;
          ne_d    = raw_end_q;
          state_d = ST_IDLE;
        end else if (cur_addr == limit_q) begin
          done_d  = 1'b1;
          cc_d    = CC_END;
          spec_d  = 1'b0;
          ns_d    = raw_start_q;
          ne_d    = raw_end_q;
          state_d = ST_IDLE;
        end else begin
          req_d   = 1'b1;
          addr_d  = cur_masked;
          state_d = ST_WAIT;
        end
      end
      ST_WAIT: begin
        if (mem_rvalid) begin
          if (mem_rdata == char_q) begin
            done_d  = 1'b1;
            cc_d    = CC_FOUND;
            spec_d  = 1'b0;
            ns_d    = raw_start_q;
            ne_d    = cur_masked;
            state_d = ST_IDLE;
          end else begin
            len_d   = len_q + LEN_STEP;
            state_d = ST_EVAL;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raw_start_q <= '0;
      raw_end_q   <= '0;
      base_q      <= '0;
      limit_q     <= '0;
      char_q      <= '0;
      amode_q     <= '0;
    end else if (cap_en) begin
      raw_start_q <= raw_start;
      raw_end_q   <= raw_end;
      base_q      <= base_in;
      limit_q     <= limit_in;
      char_q      <= char_in;
      amode_q     <= amode;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      len_q   <= '0;
      req_q   <= 1'b0;
      addr_q  <= '0;
      done_q  <= 1'b0;
      cc_q    <= CC_NONE;
      spec_q  <= 1'b0;
      ns_q    <= '0;
      ne_q    <= '0;
    end else begin
      state_q <= state_d;
      len_q   <= len_d;
      req_q   <= req_d;
      addr_q  <= addr_d;
      done_q  <= done_d;
      cc_q    <= cc_d;
      spec_q  <= spec_d;
      ns_q    <= ns_d;
      ne_q    <= ne_d;
    end
  end

  assign mem_req   = req_q;
  assign mem_addr  = addr_q;
  assign done      = done_q;
  assign cc        = cc_q;
  assign spec_err  = spec_q;
  assign new_start = ns_q;
  assign new_end   = ne_q;
endmodule

// File: rtl/strsrch_top.sv
module strsrch_top #(
  parameter int ADDR_W     = 64,
  parameter int HALF_MODE  = 0,
  parameter int SCAN_BYTES = 8192,
  parameter int UNIT_W     = (HALF_MODE != 0) ? 16 : 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [31:0]       ctl_word,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [ADDR_W-1:0] end_addr,
  input  logic [1:0]        amode,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_rvalid,
  input  logic [UNIT_W-1:0] mem_rdata,
  output logic              done,
  output logic [1:0]        cc,
  output logic              spec_err,
  output logic [ADDR_W-1:0] new_start,
  output logic [ADDR_W-1:0] new_end
);
  localparam int STEP = (HALF_MODE != 0) ? 2 : 1;

  logic [UNIT_W-1:0] search_char;
  logic              reserved_set;
  logic [ADDR_W-1:0] start_m, end_m, end_eff;

  strsrch_ctl_check #(.HALF_MODE(HALF_MODE), .UNIT_W(UNIT_W)) u_ctl (
    .ctl_word    (ctl_word),
    .search_char (search_char),
    .reserved_set(reserved_set)
  );

  strsrch_addr_mask #(.ADDR_W(ADDR_W)) u_start_mask (
    .addr_in (start_addr),
    .mode    (amode),
    .addr_out(start_m)
  );

  strsrch_addr_mask #(.ADDR_W(ADDR_W)) u_end_mask (
    .addr_in (end_addr),
    .mode    (amode),
    .addr_out(end_m)
  );

  generate
    if (HALF_MODE != 0) begin : g_parity_fix
      assign end_eff = end_m + ADDR_W'(start_m[0] ^ end_m[0]);
    end else begin : g_no_fix
      assign end_eff = end_m;
    end
  endgenerate

  strsrch_seq #(
    .ADDR_W(ADDR_W), .UNIT_W(UNIT_W), .STEP(STEP), .SCAN_BYTES(SCAN_BYTES)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .char_in   (search_char),
    .bad_in    (reserved_set),
    .raw_start (start_addr),
    .raw_end   (end_addr),
    .base_in   (start_m),
    .limit_in  (end_eff),
    .amode     (amode),
    .mem_req   (mem_req),
    .mem_addr  (mem_addr),
    .mem_rvalid(mem_rvalid),
    .mem_rdata (mem_rdata),
    .done      (done),
    .cc        (cc),
    .spec_err  (spec_err),
    .new_start (new_start),
    .new_end   (new_end)
  );
endmodule

// File: rtl/strsrch_chk.sv
module strsrch_chk #(
  parameter int ADDR_W     = 64,
  parameter int HALF_MODE  = 0,
  parameter int SCAN_BYTES = 8192
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic [1:0]        amode,
  input logic [ADDR_W-1:0] start_addr,
  input logic [ADDR_W-1:0] end_addr,
  input logic              mem_req,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              done,
  input logic [1:0]        cc,
  input logic              spec_err,
  input logic [ADDR_W-1:0] new_start,
  input logic [ADDR_W-1:0] new_end
);
  localparam int STEP   = (HALF_MODE != 0) ? 2 : 1;
  localparam int BUDGET = SCAN_BYTES / STEP;

  logic              busy_q;
  logic [ADDR_W-1:0] cap_s, cap_e, prev_addr;
  logic [1:0]        cap_am;
  logic              prev_vld;
  int unsigned       reads_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q    <= 1'b0;
      cap_s     <= '0;
      cap_e     <= '0;
      cap_am    <= '0;
      prev_addr <= '0;
      prev_vld  <= 1'b0;
      reads_q   <= 0;
    end else begin
      if (start && !busy_q) begin
        busy_q   <= 1'b1;
        cap_s    <= start_addr;
        cap_e    <= end_addr;
        cap_am   <= amode;
        prev_vld <= 1'b0;
        reads_q  <= 0;
      end else begin
        if (done) busy_q <= 1'b0;
        if (mem_req) begin
          prev_addr <= mem_addr;
          prev_vld  <= 1'b1;
          reads_q   <= reads_q + 1;
        end
      end
    end
  end

  a_r9_req_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |=> !mem_req);
  a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q |-> !mem_req);
  a_r1_spec_result: assert property (@(posedge clk) disable iff (!rst_n)
    (done && spec_err) |-> (cc == 2'd0 && new_start == cap_s && new_end == cap_e));
  a_r3_end_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (done && cc == 2'd2) |-> (new_start == cap_s && new_end == cap_e));
  a_r4_found_keeps_start: assert property (@(posedge clk) disable iff (!rst_n)
    (done && cc == 2'd1) |-> (new_start == cap_s));
  a_r5_partial_keeps_end: assert property (@(posedge clk) disable iff (!rst_n)
    (done && cc == 2'd3) |-> (new_end == cap_e));
  a_r5_read_budget: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (reads_q < BUDGET));
  a_r7_step: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && prev_vld && cap_am[1]) |-> (mem_addr == prev_addr + ADDR_W'(STEP)));
  a_r8_mask24: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && cap_am == 2'b00) |-> (mem_addr[ADDR_W-1:24] == '0));
endmodule

bind strsrch_top strsrch_chk #(
  .ADDR_W(ADDR_W), .HALF_MODE(HALF_MODE), .SCAN_BYTES(SCAN_BYTES)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .amode     (amode),
  .start_addr(start_addr),
  .end_addr  (end_addr),
  .mem_req   (mem_req),
  .mem_addr  (mem_addr),
  .done      (done),
  .cc        (cc),
  .spec_err  (spec_err),
  .new_start (new_start),
  .new_end   (new_end)
);

// File: tb/strsrch_top_test.sv
module strsrch_top_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  bit mem_flat = 1'b0;

  logic        start_b = 1'b0, start_h = 1'b0;
  logic [31:0] ctl = '0;
  logic [63:0] sa = '0, ea = '0;
  logic [1:0]  am = 2'b10;

  logic        req_b, req_h, done_b, done_h, spec_b, spec_h;
  logic [63:0] addr_b, addr_h, ns_b, ns_h, ne_b, ne_h;
  logic [1:0]  cc_b, cc_h;
  logic        rv_b = 1'b0, rv_h = 1'b0;
  logic [7:0]  rd_b = '0;
  logic [15:0] rd_h = '0;

  function automatic logic [7:0] mb(input logic [63:0] a);
    if (mem_flat) return 8'h00;
    return (a[7:0] * 8'd7) ^ a[15:8] ^ 8'h3C ^ a[23:16];
  endfunction

  function automatic logic [63:0] msk(input logic [63:0] a, input logic [1:0] m);
    if (m == 2'b00) return a & 64'h00FF_FFFF;
    if (m == 2'b01) return a & 64'h7FFF_FFFF;
    return a;
  endfunction

  always @(posedge clk) begin
    rv_b <= req_b;
    rd_b <= mb(addr_b);
    rv_h <= req_h;
    rd_h <= {mb(addr_h), mb(addr_h + 64'd1)};
  end

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 195000) begin
      total = total + 1;
      bad = bad + 1;
      $display("FAIL watchdog: run did not end");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  strsrch_top #(.HALF_MODE(0)) uut (
    .clk(clk), .rst_n(rst_n), .start(start_b), .ctl_word(ctl),
    .start_addr(sa), .end_addr(ea), .amode(am),
    .mem_req(req_b), .mem_addr(addr_b), .mem_rvalid(rv_b), .mem_rdata(rd_b),
    .done(done_b), .cc(cc_b), .spec_err(spec_b), .new_start(ns_b), .new_end(ne_b));

  strsrch_top #(.HALF_MODE(1)) uut_h (
    .clk(clk), .rst_n(rst_n), .start(start_h), .ctl_word(ctl),
    .start_addr(sa), .end_addr(ea), .amode(am),
    .mem_req(req_h), .mem_addr(addr_h), .mem_rvalid(rv_h), .mem_rdata(rd_h),
    .done(done_h), .cc(cc_h), .spec_err(spec_h), .new_start(ns_h), .new_end(ne_h));

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Expected result from the requirements.
  task automatic ref_scan(input bit half, input logic [63:0] s, e, input logic [31:0] c,
                          input logic [1:0] m, output logic [1:0] xcc, output bit xspec,
                          output logic [63:0] xns, xne);
    logic [63:0] sm, em, adj, cur;
    logic [15:0] ch, u;
    int step;
    xspec = half ? (|c[31:16]) : (|c[31:8]);
    xns = s; xne = e; xcc = 2'd0;
    if (xspec) return;
    ch = half ? c[15:0] : {8'h00, c[7:0]};
    step = half ? 2 : 1;
    sm = msk(s, m); em = msk(e, m);
    adj = em + ((half && (sm[0] ^ em[0])) ? 64'd1 : 64'd0);
    for (int len = 0; ; len += step) begin
      cur = sm + 64'(len);
      if (len == 8192) begin xcc = 2'd3; xns = msk(cur, m); return; end
      if (cur == adj) begin xcc = 2'd2; return; end
      u = half ? {mb(msk(cur, m)), mb(msk(cur, m) + 64'd1)} : {8'h00, mb(msk(cur, m))};
      if (u == ch) begin xcc = 2'd1; xne = msk(cur, m); return; end
    end
  endtask

  task automatic launch(input bit half, input logic [63:0] s, e, input logic [31:0] c,
                        input logic [1:0] m);
    @(negedge clk);
    sa = s; ea = e; ctl = c; am = m;
    if (half) start_h = 1'b1; else start_b = 1'b1;
    @(negedge clk);
    start_b = 1'b0; start_h = 1'b0;
  endtask

  task automatic collect(input bit half, input logic [1:0] xcc, input bit xspec,
                         input logic [63:0] xns, xne, input string req);
    int n = 0;
    while (!(half ? done_h : done_b) && n < 40000) begin @(negedge clk); n++; end
    check((half ? done_h : done_b) == 1'b1, {req, " done seen"}, 64'(n), 64'(0));
    check({(half ? spec_h : spec_b), (half ? cc_h : cc_b)} == {xspec, xcc},
          {req, " spec/cc"}, 64'({(half ? spec_h : spec_b), (half ? cc_h : cc_b)}),
          64'({xspec, xcc}));
    check((half ? ns_h : ns_b) == xns, {req, " new_start"}, half ? ns_h : ns_b, xns);
    check((half ? ne_h : ne_b) == xne, {req, " new_end"}, half ? ne_h : ne_b, xne);
    @(negedge clk);
    check((half ? done_h : done_b) == 1'b0, "R9 done one cycle", 64'(half ? done_h : done_b), 64'(0));
  endtask

  task automatic run(input bit half, input logic [63:0] s, e, input logic [31:0] c,
                     input logic [1:0] m, input string req);
    logic [1:0] xcc; bit xspec; logic [63:0] xns, xne;
    ref_scan(half, s, e, c, m, xcc, xspec, xns, xne);
    launch(half, s, e, c, m);
    collect(half, xcc, xspec, xns, xne, req);
  endtask

  initial begin
    logic [1:0] xcc; bit xspec; logic [63:0] xns, xne;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    check(!done_b && !req_b && cc_b == 2'd0 && !spec_b && ns_b == 0 && ne_b == 0,
          "R10 reset byte", {cc_b, spec_b, done_b, req_b}, 64'd0);
    check(!done_h && !req_h && cc_h == 2'd0 && !spec_h && ns_h == 0 && ne_h == 0,
          "R10 reset half", {cc_h, spec_h, done_h, req_h}, 64'd0);

    // R1 / R2 reserved bits
    run(0, 64'h100, 64'h180, 32'h0000_0141, 2'b10, "R1 byte reserved bit 8");
    run(0, 64'h100, 64'h180, 32'h8000_0000, 2'b10, "R1 byte reserved bit 31");
    run(1, 64'h100, 64'h180, 32'h0001_0000, 2'b10, "R2 half reserved bit 16");
    run(1, 64'h100, 64'h180, 32'h0000_ABCD, 2'b10, "R2 half full 16-bit char");

    // R3 empty string, R4 found at first unit
    run(0, 64'h2000, 64'h2000, 32'h5A, 2'b10, "R3 empty string");
    run(0, 64'h2345, 64'h2400, {24'h0, mb(64'h2345)}, 2'b10, "R4 found first byte");
    run(1, 64'h2346, 64'h2400, {16'h0, mb(64'h2346), mb(64'h2347)}, 2'b10, "R4 found first half");

    // R5 / R7 budget boundaries with a flat memory
    mem_flat = 1'b1;
    run(0, 64'h1_0000, 64'h1_1FFF, 32'h55, 2'b10, "R5 end at 8191 gives cc2");
    run(0, 64'h1_0000, 64'h1_2000, 32'h55, 2'b10, "R5 budget beats end");
    run(1, 64'h3_0000, 64'h2_0000, 32'h5555, 2'b10, "R5 R7 half budget resume");
    // R6 parity correction
    run(1, 64'h1000, 64'h1005, 32'h5555, 2'b10, "R6 odd end stops");
    run(1, 64'h1001, 64'h1004, 32'h5555, 2'b10, "R6 odd start stops");
    // R8 masking with upper junk
    run(0, 64'hFFFF_FF00_0012_3400, 64'h0, 32'h55, 2'b00, "R8 24-bit resume");
    run(0, 64'hFFFF_FFFF_8000_0010, 64'h0000_0001_0000_0018, 32'h55, 2'b01, "R8 31-bit end");

    // R9 start while busy is ignored
    ref_scan(0, 64'h5_0000, 64'h4_0000, 32'h33, 2'b10, xcc, xspec, xns, xne);
    launch(0, 64'h5_0000, 64'h4_0000, 32'h33, 2'b10);
    repeat (50) @(negedge clk);
    launch(0, 64'h6_0000, 64'h6_0000, 32'h44, 2'b10);
    collect(0, xcc, xspec, xns, xne, "R9 busy start ignored");
    mem_flat = 1'b0;
    run(0, 64'hFF00_0000_0040_0010, 64'hFF00_0000_0040_0080,
        {24'h0, mb(64'h0040_0030)}, 2'b00, "R8 R4 24-bit found");

    // Random mix
    for (int i = 0; i < 80; i++) begin
      bit half = i[0];
      logic [63:0] s = {$urandom, $urandom};
      int len = $urandom_range(0, 120);
      logic [1:0] m = 2'($urandom_range(0, 2));
      logic [63:0] e = s + 64'(len);
      logic [31:0] c;
      logic [63:0] pa = msk(s, m) + 64'($urandom_range(0, 60) * (half ? 2 : 1));
      if ($urandom_range(0, 1) == 0) c = half ? {16'h0, mb(pa), mb(pa + 64'd1)} : {24'h0, mb(pa)};
      else c = half ? {16'h0, 16'($urandom)} : {24'h0, 8'($urandom)};
      if ($urandom_range(0, 9) == 0) c[31:24] = 8'($urandom_range(1, 255));
      run(half, s, e, c, m, half ? "R2 R4 R7 random half" : "R1 R3 R4 R8 random byte");
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule